// File: doc/BRIEF.md
# Multidrop 9-bit Serial Receiver with Address Wake-up

This block receives asynchronous serial frames on a shared multidrop line where each frame carries nine payload bits. The last payload bit tells an address frame (1) from a data frame (0). A station uses this bit, together with its own 8-bit station address, to decide which traffic concerns it.

The block keeps a wake-up flag. Software sets the flag to put the station in the listening state. While the flag is set, data frames and address frames for other stations are dropped without an interrupt. An address frame whose low byte equals the station address clears the flag in hardware. After that, every correctly framed frame is delivered with a one-cycle receive-valid pulse, the received byte and the received ninth bit. Software can then spot a later address frame by looking at the ninth bit.

The line is sampled on an oversampling tick, with OSR ticks per bit. A start bit is confirmed at the middle of the bit. Each bit is decided by a majority vote over three samples at the centre of the bit. A frame whose stop bit reads 0 is discarded and reported with a framing-error pulse.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset the wake flag is 0, rx_valid and frame_err are 0, and rx_byte and rx_bit8 are 0.
- R2: A frame is a low start bit, then nine payload bits with bit 0 first and bit 8 last, then a high stop bit, each lasting OSR ticks of os_tick. A low pulse shorter than half a bit is not taken as a start bit and produces no output.
- R3: Each bit value is the majority of three samples taken at ticks OSR/2-1, OSR/2 and OSR/2+1 of the bit. A single wrong sample among them does not change the value.
- R4: With the wake flag at 0, each frame with a good stop bit gives exactly one rx_valid pulse of one cycle. rx_byte holds payload bits 7..0 and rx_bit8 holds payload bit 8. Address frames are delivered the same way.
- R5: With the wake flag at 1, a frame whose bit 8 is 0 gives no rx_valid, and the flag stays 1.
- R6: With the wake flag at 1, a frame whose bit 8 is 1 and whose bits 7..0 equal station_addr clears the flag to 0 and gives no rx_valid.
- R7: With the wake flag at 1, a frame whose bit 8 is 1 and whose bits 7..0 differ from station_addr leaves the flag at 1 and gives no rx_valid.
- R8: A wake_set pulse sets the flag to 1 on the next clock edge. This takes priority over a hardware clear in the same cycle.
- R9: A frame whose stop bit is sampled 0 gives a one-cycle frame_err pulse and no rx_valid, and leaves the wake flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Serial receive line; idles high |
| os_tick | input | 1 | Oversampling tick, OSR per bit time |
| station_addr | input | WORD_W | The station's own select code |
| wake_set | input | 1 | One-cycle write pulse that sets the wake flag |
| rx_byte | output | WORD_W | Low payload bits of the last delivered frame |
| rx_bit8 | output | 1 | Ninth payload bit of the last delivered frame |
| rx_valid | output | 1 | One-cycle receive interrupt pulse |
| frame_err | output | 1 | One-cycle pulse when a stop bit reads 0 |
| wake_flag | output | 1 | Current state of the wake-up flag |

## Verification
The bench builds the block with OSR = 8 and WORD_W = 8, and gives it an os_tick every third clock. A bit therefore lasts 24 clocks. This keeps every frame short, and it still leaves a clear gap between the three centre samples and the bit edges. With this spacing, a three-clock glitch corrupts exactly one vote sample, and a two-tick low pulse falls short of a mid-bit start confirmation. The bench can also hold wake_set across the end of a matching address frame, so the set/clear collision lands within reach.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  typedef enum logic [0:0] {
    RS_IDLE  = 1'b0,
    RS_FRAME = 1'b1
  } rx_state_e;

  // majority of three line samples
  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // next wake flag: software set wins over hardware clear
  function automatic logic wake_next(input logic cur, input logic sw_set, input logic hw_clr);
    if (sw_set) return 1'b1;
    if (hw_clr) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpr_bit_sampler.sv
module mpr_bit_sampler
  import mpr_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_s,
  input  logic              tick,
  output logic              done,
  output logic              stop_ok,
  output logic [WORD_W:0]   word
);
  localparam int NBITS = WORD_W + 1;
  localparam int MID   = OSR / 2;
  localparam int CNT_W = $clog2(OSR);
  localparam int IDX_W = $clog2(NBITS + 2);
  localparam logic [CNT_W-1:0] C_S0   = CNT_W'(MID - 1);
  localparam logic [CNT_W-1:0] C_S1   = CNT_W'(MID);
  localparam logic [CNT_W-1:0] C_S2   = CNT_W'(MID + 1);
  localparam logic [CNT_W-1:0] C_LAST = CNT_W'(OSR - 1);
  localparam logic [IDX_W-1:0] I_LAST = IDX_W'(NBITS);

  rx_state_e        state;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             smp0, smp1;
  logic [WORD_W:0]  shreg;

  // named events for checking
  logic bit_vote, decide, false_start;
  assign bit_vote    = vote3(smp0, smp1, rxd_s);
  assign decide      = tick && state == RS_FRAME && cnt == C_S2;
  assign false_start = decide && idx == '0 && bit_vote;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RS_IDLE;
      cnt     <= '0;
      idx     <= '0;
      smp0    <= 1'b0;
      smp1    <= 1'b0;
      shreg   <= '0;
      done    <= 1'b0;
      stop_ok <= 1'b0;
      word    <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          RS_IDLE: begin
            if (!rxd_s) begin
              state <= RS_FRAME;
              cnt   <= CNT_W'(1);
              idx   <= '0;
            end
          end
          default: begin
            if (cnt == C_S0) smp0 <= rxd_s;
            if (cnt == C_S1) smp1 <= rxd_s;
            if (cnt == C_S2) begin
              if (idx == '0) begin
                if (bit_vote) state <= RS_IDLE;
              end else if (idx <= I_LAST) begin
                shreg <= {bit_vote, shreg[WORD_W:1]};
              end else begin
                done    <= 1'b1;
                stop_ok <= bit_vote;
                word    <= shreg;
                state   <= RS_IDLE;
              end
            end
            if (cnt == C_LAST) begin
              cnt <= '0;
              idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

  // R2: a finished frame is only ever reported on a tick cycle
  a_r2_done_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tick));
  // R2: a rejected start bit returns to idle without reporting a frame
  a_r2_false_start_silent: assert property (@(posedge clk) disable iff (!rst_n)
    false_start |=> (!done && state == RS_IDLE));
endmodule

// File: rtl/mpr_wake_filter.sv
module mpr_wake_filter
  import mpr_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              stop_ok,
  input  logic [WORD_W:0]   word,
  input  logic [WORD_W-1:0] station_addr,
  input  logic              wake_set,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_bit8,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              wake_flag
);
  logic frame_good, is_addr, addr_match, hw_clr, deliver;
  assign frame_good = done && stop_ok;
  assign is_addr    = word[WORD_W];
  assign addr_match = is_addr && (word[WORD_W-1:0] == station_addr);
  assign hw_clr     = frame_good && wake_flag && addr_match;
  assign deliver    = frame_good && !wake_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_byte   <= '0;
      rx_bit8   <= 1'b0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      wake_flag <= 1'b0;
    end else begin
      rx_valid  <= deliver;
      frame_err <= done && !stop_ok;
      if (deliver) begin
        rx_byte <= word[WORD_W-1:0];
        rx_bit8 <= word[WORD_W];
      end
      wake_flag <= wake_next(wake_flag, wake_set, hw_clr);
    end
  end

  // R4: awake station delivers the frame, ninth bit included
  a_r4_deliver_awake: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_ok && !wake_flag) |=> (rx_valid && rx_bit8 == $past(word[WORD_W])));
  // R5: sleeping station drops data frames
  a_r5_sleep_drops_data: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wake_flag && !word[WORD_W]) |=> (!rx_valid && wake_flag));
  // R6: matching address wakes the station silently
  a_r6_match_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (done && stop_ok && wake_flag && word[WORD_W] && word[WORD_W-1:0] == station_addr && !wake_set)
      |=> (!wake_flag && !rx_valid));
  // R7: foreign address leaves the station asleep
  a_r7_mismatch_sleeps: assert property (@(posedge clk) disable iff (!rst_n)
    (done && wake_flag && word[WORD_W-1:0] != station_addr) |=> (wake_flag && !rx_valid));
  // R8: software set always lands
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wake_set |=> wake_flag);
  // R9: framing error keeps the flag and raises no interrupt
  a_r9_ferr_keeps_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !stop_ok && !wake_set) |=> ($stable(wake_flag) && frame_err && !rx_valid));
  // R9: error and delivery never coincide
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && frame_err));
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int OSR    = 16,
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd,
  input  logic              os_tick,
  input  logic [WORD_W-1:0] station_addr,
  input  logic              wake_set,
  output logic [WORD_W-1:0] rx_byte,
  output logic              rx_bit8,
  output logic              rx_valid,
  output logic              frame_err,
  output logic              wake_flag
);
  logic            rxd_s;
  logic            frm_done;
  logic            frm_stop_ok;
  logic [WORD_W:0] frm_word;

  mpr_sync #(.STAGES(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (rxd_s)
  );

  mpr_bit_sampler #(.OSR(OSR), .WORD_W(WORD_W)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_s  (rxd_s),
    .tick   (os_tick),
    .done   (frm_done),
    .stop_ok(frm_stop_ok),
    .word   (frm_word)
  );

  mpr_wake_filter #(.WORD_W(WORD_W)) u_filter (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (frm_done),
    .stop_ok     (frm_stop_ok),
    .word        (frm_word),
    .station_addr(station_addr),
    .wake_set    (wake_set),
    .rx_byte     (rx_byte),
    .rx_bit8     (rx_bit8),
    .rx_valid    (rx_valid),
    .frame_err   (frame_err),
    .wake_flag   (wake_flag)
  );

  // R1: outputs quiet right after reset release
  a_r1_reset_quiet: assert property (@(posedge clk) $rose(rst_n) |-> (!rx_valid && !frame_err && !wake_flag));
endmodule

// File: tb/tb_mp_uart_rx.sv
module tb_mp_uart_rx;
  localparam int OSR  = 8;
  localparam int TDIV = 3;
  localparam int BITC = OSR * TDIV;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic [7:0] station_addr = 8'h0A;
  logic       wake_set = 1'b0;
  logic [7:0] rx_byte;
  logic       rx_bit8, rx_valid, frame_err, wake_flag;

  int checks = 0, errors = 0;
  int vcnt = 0, ecnt = 0, prio_viol = 0;
  logic [7:0] last_byte = '0;
  logic       last_b8 = 1'b0;
  logic       set_prev = 1'b0;

  mp_uart_rx #(.OSR(OSR), .WORD_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .station_addr(station_addr), .wake_set(wake_set),
    .rx_byte(rx_byte), .rx_bit8(rx_bit8), .rx_valid(rx_valid),
    .frame_err(frame_err), .wake_flag(wake_flag)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      os_tick = 1'b1;
      @(negedge clk);
      os_tick = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rx_valid) begin
      vcnt++;
      last_byte = rx_byte;
      last_b8   = rx_bit8;
    end
    if (frame_err) ecnt++;
    if (rst_n && set_prev && wake_set && !wake_flag) prio_viol++;
    set_prev = wake_set;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // glitch_bit >= 0 inverts three clocks near the centre of that payload bit
  task automatic send_frame(input logic [8:0] w, input logic stop, input int glitch_bit);
    hold(1'b0, BITC);
    for (int i = 0; i < 9; i++) begin
      if (i == glitch_bit) begin
        hold(w[i], 12);
        hold(~w[i], 3);
        hold(w[i], BITC - 15);
      end else begin
        hold(w[i], BITC);
      end
    end
    hold(stop, BITC);
    hold(1'b1, 2 * BITC);
  endtask

  task automatic pulse_set();
    wake_set = 1'b1;
    @(negedge clk);
    wake_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(!wake_flag && !rx_valid && !frame_err, "R1 outputs after reset",
          {wake_flag, rx_valid, frame_err}, 0);
    check(rx_byte == 8'h00 && !rx_bit8, "R1 data after reset", {rx_bit8, rx_byte}, 0);
  endtask

  task automatic t_awake_data();
    int v0 = vcnt;
    send_frame(9'h0A5, 1'b1, -1);
    check(vcnt == v0 + 1, "R4 one pulse per frame", vcnt - v0, 1);
    check(last_byte == 8'hA5 && !last_b8, "R2 bit order data frame", {last_b8, last_byte}, 9'h0A5);
  endtask

  task automatic t_awake_addr();
    int v0 = vcnt;
    send_frame(9'h13C, 1'b1, -1);
    check(vcnt == v0 + 1 && last_b8 && last_byte == 8'h3C, "R4 address frame seen when awake",
          {last_b8, last_byte}, 9'h13C);
  endtask

  task automatic t_false_start();
    int v0 = vcnt, e0 = ecnt;
    hold(1'b0, 2 * TDIV);
    hold(1'b1, 4 * BITC);
    check(vcnt == v0 && ecnt == e0, "R2 short low pulse ignored", vcnt - v0 + ecnt - e0, 0);
    send_frame(9'h066, 1'b1, -1);
    check(vcnt == v0 + 1 && last_byte == 8'h66, "R2 frame after glitch", last_byte, 8'h66);
  endtask

  task automatic t_majority();
    int v0 = vcnt;
    send_frame(9'h055, 1'b1, 2);
    check(vcnt == v0 + 1 && last_byte == 8'h55, "R3 one bad centre sample outvoted", last_byte, 8'h55);
    send_frame(9'h0AA, 1'b1, 7);
    check(last_byte == 8'hAA, "R3 vote on bit 7", last_byte, 8'hAA);
  endtask

  task automatic t_sleep();
    int v0;
    pulse_set();
    check(wake_flag, "R8 set pulse raises flag", wake_flag, 1);
    v0 = vcnt;
    send_frame(9'h0A5, 1'b1, -1);
    check(vcnt == v0 && wake_flag, "R5 data dropped while asleep", vcnt - v0, 0);
    send_frame(9'h10B, 1'b1, -1);
    check(vcnt == v0 && wake_flag, "R7 foreign address ignored", {vcnt - v0, wake_flag}, 1);
  endtask

  task automatic t_ferr();
    int v0 = vcnt, e0 = ecnt;
    send_frame(9'h10A, 1'b0, -1);
    check(ecnt == e0 + 1, "R9 framing error pulse", ecnt - e0, 1);
    check(vcnt == v0 && wake_flag, "R9 flag kept, no interrupt", {vcnt - v0, wake_flag}, 1);
  endtask

  task automatic t_match();
    int v0 = vcnt;
    send_frame(9'h10A, 1'b1, -1);
    check(!wake_flag && vcnt == v0, "R6 match clears flag silently", {wake_flag, vcnt - v0}, 0);
    send_frame(9'h033, 1'b1, -1);
    send_frame(9'h0C4, 1'b1, -1);
    check(vcnt == v0 + 2 && last_byte == 8'hC4, "R4 data after wake-up", vcnt - v0, 2);
  endtask

  task automatic t_priority();
    wake_set = 1'b1;
    send_frame(9'h10A, 1'b1, -1);
    wake_set = 1'b0;
    @(negedge clk);
    check(prio_viol == 0 && wake_flag, "R8 set beats same-cycle clear", prio_viol, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_awake_data();
    t_awake_addr();
    t_false_start();
    t_majority();
    t_sleep();
    t_ferr();
    t_match();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule